// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Scoped Invalidation

This block is a small, fully associative translation cache for a 32-bit, two-level paged memory management unit. Each entry holds a 20-bit virtual page number, a 22-bit physical page number, a 9-bit address-space identifier and a global flag. A lookup gives only a virtual page number. The current identifier and the translation-enable bit come from the 32-bit translation base register, which the block decodes itself. When translation is off, the block returns the virtual page unchanged as the physical page.

An external page-table walker installs entries through a valid/ready refill port. The operating system removes stale entries through a fence port. The fence has an optional page operand and an optional identifier operand. Together with each entry's global flag, these operands decide exactly which entries are dropped. Identifier zero is an ordinary identifier: only the per-entry global flag makes a mapping shared.

Each cycle the update logic takes one of four actions. **ACT_IDLE** leaves the entries alone. **ACT_FENCE** drops the entries the fence selects. **ACT_FILL** writes a refill. **ACT_FENCE_FILL** first drops the selected entries and then writes the refill. The fence uses one of four scopes, **FSCOPE_ALL**, **FSCOPE_ASID**, **FSCOPE_PAGE** and **FSCOPE_PAGE_ASID**, encoded as {page given, identifier given}. A replacement pointer advances from **0** to **ENTRIES-1** and then wraps to **0**. It advances only when a refill finds no free entry.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits when an entry is valid, its page equals the requested page, and the entry is global or its identifier equals the current identifier. Hit flag and physical page appear on the response outputs in the cycle after the request.
- R2: With translation off (base register bit 31 = 0), every lookup hits and returns the virtual page zero-extended to 22 bits.
- R3: The base register is decoded as bit 31 = enable, bits 30:22 = current identifier. Bits 21:0 (root page) do not affect lookups.
- R4: A fence with neither operand (scope code 2'b00) drops every entry, global ones included.
- R5: A fence with only an identifier (code 2'b01) drops exactly the non-global entries whose identifier matches it.
- R6: A fence with only a page (code 2'b10) drops every entry with that page, for all identifiers, global ones included.
- R7: A fence with both operands (code 2'b11) drops exactly the non-global entries that match both the page and the identifier.
- R8: Identifier 0 is not global: a non-global entry tagged 0 misses under any other identifier, and an identifier-0 fence never drops global entries.
- R9: A refill writes the lowest-index invalid entry. If no entry is invalid, it writes the entry at the replacement pointer, which then advances by one and wraps. The pointer starts at 0 after reset.
- R10: When a fence and a refill arrive in the same cycle, the fence acts first and the refilled entry survives.
- R11: After reset no entry is valid and no response is signalled. Refill ready is low during reset and high from the first cycle after it.
- R12: A cycle with no lookup request gives a low response-valid and a low hit in the following cycle.
- R13: Tags compare page numbers only, without carry: page 0xFFFFF and page 0x00000 are distinct entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| satp_i | input | 32 | Translation base register (enable, identifier, root page) |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | 20 | Virtual page to translate |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | Translation found |
| rsp_ppn_o | output | 22 | Physical page of the hit |
| fill_valid_i | input | 1 | Refill request |
| fill_ready_o | output | 1 | Refill accepted |
| fill_vpn_i | input | 20 | Refill virtual page |
| fill_ppn_i | input | 22 | Refill physical page |
| fill_asid_i | input | 9 | Refill identifier |
| fill_global_i | input | 1 | Refill global flag |
| fence_valid_i | input | 1 | Fence request |
| fence_has_va_i | input | 1 | Page operand present |
| fence_vpn_i | input | 20 | Page operand (virtual page of the fence address) |
| fence_has_asid_i | input | 1 | Identifier operand present |
| fence_asid_i | input | 9 | Identifier operand |

## Verification
The checks assume the refill port never installs a second entry that could hit for the same page and identifier. The response logic ORs the matching entries together, so a duplicate would make the returned page ambiguous. The stimulus respects this by using distinct page numbers within every loaded set and by flushing before each set is reloaded. The assertions also take the fence operand bits as meaningful only while a fence is valid. They check the scope rules only in cycles without a refill, because a refill can legitimately revalidate an entry in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W          = 32;
    localparam int PAGE_OFS      = 12;
    localparam int VPN_W         = VA_W - PAGE_OFS;
    localparam int PPN_W         = 22;
    localparam int ASID_W        = 9;
    localparam int SATP_MODE_BIT = 31;
    localparam int SATP_ASID_LSB = SATP_MODE_BIT - ASID_W;

    typedef enum logic [1:0] {
        ACT_IDLE       = 2'd0,
        ACT_FENCE      = 2'd1,
        ACT_FILL       = 2'd2,
        ACT_FENCE_FILL = 2'd3
    } tlb_act_e;

    typedef enum logic [1:0] {
        FSCOPE_ALL       = 2'b00,
        FSCOPE_ASID      = 2'b01,
        FSCOPE_PAGE      = 2'b10,
        FSCOPE_PAGE_ASID = 2'b11
    } fence_scope_e;
endpackage

// File: rtl/tlb_fence_sel.sv
module tlb_fence_sel
    import tlb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]             vld_i,
    input  logic [N-1:0]             glob_i,
    input  logic [N-1:0][VPN_W-1:0]  vpn_i,
    input  logic [N-1:0][ASID_W-1:0] asid_i,
    input  logic                     has_va_i,
    input  logic                     has_asid_i,
    input  logic [VPN_W-1:0]         fence_vpn_i,
    input  logic [ASID_W-1:0]        fence_asid_i,
    output logic [N-1:0]             kill_o
);
    fence_scope_e scope;

    always_comb begin
        scope = fence_scope_e'({has_va_i, has_asid_i});
    end

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic page_eq;
        logic asid_eq;
        logic sel;

        always_comb begin
            page_eq = (vpn_i[i] == fence_vpn_i);
            asid_eq = (asid_i[i] == fence_asid_i);
            unique case (scope)
                FSCOPE_ALL:       sel = 1'b1;
                FSCOPE_ASID:      sel = !glob_i[i] && asid_eq;
                FSCOPE_PAGE:      sel = page_eq;
                FSCOPE_PAGE_ASID: sel = !glob_i[i] && asid_eq && page_eq;
                default:          sel = 1'b0;
            endcase
        end

        assign kill_o[i] = vld_i[i] & sel;
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]             vld_i,
    input  logic [N-1:0]             glob_i,
    input  logic [N-1:0][VPN_W-1:0]  vpn_i,
    input  logic [N-1:0][PPN_W-1:0]  ppn_i,
    input  logic [N-1:0][ASID_W-1:0] asid_i,
    input  logic [ASID_W-1:0]        cur_asid_i,
    input  logic [VPN_W-1:0]         req_vpn_i,
    output logic                     hit_o,
    output logic [PPN_W-1:0]         ppn_o
);
    logic [N-1:0] hit_vec;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = vld_i[i]
                          && (vpn_i[i] == req_vpn_i)
                          && (glob_i[i] || (asid_i[i] == cur_asid_i));
    end

    always_comb begin
        ppn_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                ppn_o = ppn_o | ppn_i[i];
            end
        end
        hit_o = |hit_vec;
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] vld_i,
    input  logic         take_i,
    output logic [N-1:0] way_oh_o
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] first_free;
    logic             any_free;

    always_comb begin
        first_free = '0;
        any_free   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                first_free = IDX_W'(i);
                any_free   = 1'b1;
            end
        end
    end

    always_comb begin
        way_oh_o = '0;
        if (any_free) begin
            way_oh_o[first_free] = 1'b1;
        end else begin
            way_oh_o[ptr_q] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take_i && !any_free) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   satp_i,
    input  logic              lkp_valid_i,
    input  logic [VPN_W-1:0]  lkp_vpn_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [PPN_W-1:0]  rsp_ppn_o,
    input  logic              fill_valid_i,
    output logic              fill_ready_o,
    input  logic [VPN_W-1:0]  fill_vpn_i,
    input  logic [PPN_W-1:0]  fill_ppn_i,
    input  logic [ASID_W-1:0] fill_asid_i,
    input  logic              fill_global_i,
    input  logic              fence_valid_i,
    input  logic              fence_has_va_i,
    input  logic [VPN_W-1:0]  fence_vpn_i,
    input  logic              fence_has_asid_i,
    input  logic [ASID_W-1:0] fence_asid_i
);
    localparam int ZEXT_W = PPN_W - VPN_W;

    logic [ENTRIES-1:0]             vld_q;
    logic [ENTRIES-1:0]             glob_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;

    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] vld_post;
    logic [ENTRIES-1:0] vld_d;
    logic [ENTRIES-1:0] way_oh;

    logic              rdy_q;
    logic              fill_fire;
    logic              xlate_on;
    logic [ASID_W-1:0] cur_asid;
    logic              unused_root_ppn;
    logic              m_hit;
    logic [PPN_W-1:0]  m_ppn;
    tlb_act_e          act;

    logic              rsp_valid_q;
    logic              rsp_hit_q;
    logic [PPN_W-1:0]  rsp_ppn_q;

    assign xlate_on        = satp_i[SATP_MODE_BIT];
    assign cur_asid        = satp_i[SATP_MODE_BIT-1 -: ASID_W];
    assign unused_root_ppn = ^satp_i[SATP_ASID_LSB-1:0];
    assign fill_fire       = fill_valid_i & rdy_q;
    assign fill_ready_o    = rdy_q;

    tlb_fence_sel #(.N(ENTRIES)) u_fence (
        .vld_i        (vld_q),
        .glob_i       (glob_q),
        .vpn_i        (vpn_q),
        .asid_i       (asid_q),
        .has_va_i     (fence_has_va_i),
        .has_asid_i   (fence_has_asid_i),
        .fence_vpn_i  (fence_vpn_i),
        .fence_asid_i (fence_asid_i),
        .kill_o       (kill)
    );

    tlb_match #(.N(ENTRIES)) u_match (
        .vld_i      (vld_q),
        .glob_i     (glob_q),
        .vpn_i      (vpn_q),
        .ppn_i      (ppn_q),
        .asid_i     (asid_q),
        .cur_asid_i (cur_asid),
        .req_vpn_i  (lkp_vpn_i),
        .hit_o      (m_hit),
        .ppn_o      (m_ppn)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (vld_post),
        .take_i   (fill_fire),
        .way_oh_o (way_oh)
    );

    // action select: fence first, refill on top of the surviving set
    always_comb begin
        act = tlb_act_e'({fill_fire, fence_valid_i});
    end

    always_comb begin
        unique case (act)
            ACT_IDLE: begin
                vld_post = vld_q;
                vld_d    = vld_q;
            end
            ACT_FENCE: begin
                vld_post = vld_q & ~kill;
                vld_d    = vld_post;
            end
            ACT_FILL: begin
                vld_post = vld_q;
                vld_d    = vld_q | way_oh;
            end
            ACT_FENCE_FILL: begin
                vld_post = vld_q & ~kill;
                vld_d    = vld_post | way_oh;
            end
            default: begin
                vld_post = vld_q;
                vld_d    = vld_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            vld_q <= vld_d;
            rdy_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_q <= '0;
            vpn_q  <= '0;
            ppn_q  <= '0;
            asid_q <= '0;
        end else if (fill_fire) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (way_oh[i]) begin
                    glob_q[i] <= fill_global_i;
                    vpn_q[i]  <= fill_vpn_i;
                    ppn_q[i]  <= fill_ppn_i;
                    asid_q[i] <= fill_asid_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_ppn_q   <= '0;
        end else begin
            rsp_valid_q <= lkp_valid_i;
            if (!lkp_valid_i) begin
                rsp_hit_q <= 1'b0;
                rsp_ppn_q <= '0;
            end else if (xlate_on) begin
                rsp_hit_q <= m_hit;
                rsp_ppn_q <= m_ppn;
            end else begin
                rsp_hit_q <= 1'b1;
                rsp_ppn_q <= {{ZEXT_W{1'b0}}, lkp_vpn_i};
            end
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_hit_o   = rsp_hit_q;
    assign rsp_ppn_o   = rsp_ppn_q;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk
    import tlb_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [VA_W-1:0]   satp_i,
    input logic              lkp_valid_i,
    input logic [VPN_W-1:0]  lkp_vpn_i,
    input logic              rsp_valid_o,
    input logic              rsp_hit_o,
    input logic [PPN_W-1:0]  rsp_ppn_o,
    input logic              fill_valid_i,
    input logic              fill_ready_o,
    input logic              fence_valid_i,
    input logic              fence_has_va_i,
    input logic              fence_has_asid_i,
    input logic [N-1:0]      vld_q,
    input logic [N-1:0]      glob_q
);
    localparam int ZEXT_W = PPN_W - VPN_W;

    AST_RSP_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid_i |=> rsp_valid_o); // R1

    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid_i |=> (!rsp_valid_o && !rsp_hit_o)); // R12

    AST_BARE_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid_i && !satp_i[SATP_MODE_BIT]) |=>
        (rsp_hit_o && rsp_ppn_o == {{ZEXT_W{1'b0}}, $past(lkp_vpn_i)})); // R2

    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_valid_i && !fence_has_va_i && !fence_has_asid_i && !fill_valid_i)
        |=> (vld_q == '0)); // R4

    AST_ASID_FENCE_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_valid_i && fence_has_asid_i && !fill_valid_i) |=>
        ($countones(vld_q & glob_q) == $past($countones(vld_q & glob_q)))); // R5 R7

    AST_FILL_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_i && fill_ready_o) |=> (vld_q != '0)); // R10
endmodule

bind asid_tlb asid_tlb_chk #(.N(ENTRIES)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .satp_i           (satp_i),
    .lkp_valid_i      (lkp_valid_i),
    .lkp_vpn_i        (lkp_vpn_i),
    .rsp_valid_o      (rsp_valid_o),
    .rsp_hit_o        (rsp_hit_o),
    .rsp_ppn_o        (rsp_ppn_o),
    .fill_valid_i     (fill_valid_i),
    .fill_ready_o     (fill_ready_o),
    .fence_valid_i    (fence_valid_i),
    .fence_has_va_i   (fence_has_va_i),
    .fence_has_asid_i (fence_has_asid_i),
    .vld_q            (vld_q),
    .glob_q           (glob_q)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] satp_i = '0;
    logic        lkp_valid_i = 1'b0;
    logic [19:0] lkp_vpn_i = '0;
    logic        rsp_valid_o;
    logic        rsp_hit_o;
    logic [21:0] rsp_ppn_o;
    logic        fill_valid_i = 1'b0;
    logic        fill_ready_o;
    logic [19:0] fill_vpn_i = '0;
    logic [21:0] fill_ppn_i = '0;
    logic [8:0]  fill_asid_i = '0;
    logic        fill_global_i = 1'b0;
    logic        fence_valid_i = 1'b0;
    logic        fence_has_va_i = 1'b0;
    logic [19:0] fence_vpn_i = '0;
    logic        fence_has_asid_i = 1'b0;
    logic [8:0]  fence_asid_i = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // reference model state
    logic        m_v [N];
    logic        m_g [N];
    logic [19:0] m_vpn [N];
    logic [21:0] m_ppn [N];
    logic [8:0]  m_asid [N];
    int          m_ptr = 0;

    asid_tlb #(.ENTRIES(N)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL R11 watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [22:0] model_lookup(logic [19:0] vpn, logic [8:0] asid);
        logic [22:0] r = '0;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == asid)) begin
                r = {1'b1, m_ppn[i]};
            end
        end
        return r;
    endfunction

    task automatic model_fence(logic hv, logic [19:0] vpn, logic ha, logic [8:0] asid);
        for (int i = 0; i < N; i++) begin
            logic pm = (m_vpn[i] == vpn);
            logic am = (m_asid[i] == asid);
            logic k;
            case ({hv, ha})
                2'b00:   k = 1'b1;
                2'b01:   k = !m_g[i] && am;
                2'b10:   k = pm;
                default: k = !m_g[i] && am && pm;
            endcase
            if (k) m_v[i] = 1'b0;
        end
    endtask

    task automatic model_fill(logic [19:0] vpn, logic [21:0] ppn, logic [8:0] asid, logic g);
        int w = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!m_v[i]) w = i;
        end
        if (w < 0) begin
            w = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        m_v[w] = 1'b1; m_g[w] = g; m_vpn[w] = vpn; m_ppn[w] = ppn; m_asid[w] = asid;
    endtask

    task automatic op(logic fe, logic hv, logic [19:0] fvpn, logic ha, logic [8:0] fasid,
                      logic fi, logic [19:0] vpn, logic [21:0] ppn, logic [8:0] asid, logic g);
        @(negedge clk);
        fence_valid_i = fe; fence_has_va_i = hv; fence_vpn_i = fvpn;
        fence_has_asid_i = ha; fence_asid_i = fasid;
        fill_valid_i = fi; fill_vpn_i = vpn; fill_ppn_i = ppn;
        fill_asid_i = asid; fill_global_i = g;
        @(negedge clk);
        fence_valid_i = 1'b0; fill_valid_i = 1'b0;
        if (fe) model_fence(hv, fvpn, ha, fasid);
        if (fi) model_fill(vpn, ppn, asid, g);
    endtask

    task automatic fill(logic [19:0] vpn, logic [21:0] ppn, logic [8:0] asid, logic g);
        op(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, vpn, ppn, asid, g);
    endtask

    task automatic fence(logic hv, logic [19:0] fvpn, logic ha, logic [8:0] fasid);
        op(1'b1, hv, fvpn, ha, fasid, 1'b0, '0, '0, '0, 1'b0);
    endtask

    // satp: bit31 enable, 30:22 identifier, 21:0 root page (noise)
    task automatic lookup(string tag, logic on, logic [8:0] asid, logic [19:0] vpn);
        logic [22:0] e;
        @(negedge clk);
        satp_i = {on, asid, 22'h2A5C3 ^ {13'd0, asid}};
        lkp_valid_i = 1'b1; lkp_vpn_i = vpn;
        @(negedge clk);
        lkp_valid_i = 1'b0;
        e = on ? model_lookup(vpn, asid) : {1'b1, 2'b00, vpn};
        chk({tag, " rsp_valid"}, {31'd0, rsp_valid_o}, 32'd1);
        chk(tag, {9'd0, rsp_hit_o, rsp_ppn_o}, {9'd0, e});
    endtask

    task automatic sweep(string tag, logic [19:0] base, int cnt);
        for (int a = 0; a < 4; a++) begin
            for (int v = 0; v <= cnt; v++) begin
                lookup(tag, 1'b1, 9'(a), base + 20'(v));
            end
        end
    endtask

    // standard set: pages 0x100..0x107, identifiers i%3, globals at 3 (id 0) and 5 (id 2)
    task automatic load_std();
        fence(1'b0, '0, 1'b0, '0);
        for (int i = 0; i < N; i++) begin
            fill(20'h100 + 20'(i), 22'h2000 + 22'(i), 9'(i % 3), (i == 3) || (i == 5));
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_g[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_asid[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R11 rsp_valid in reset", {31'd0, rsp_valid_o}, 32'd0);
        chk("R11 ready in reset", {31'd0, fill_ready_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ready after reset", {31'd0, fill_ready_o}, 32'd1);
        chk("R12 idle rsp", {30'd0, rsp_valid_o, rsp_hit_o}, 32'd0);
        sweep("R11 empty", 20'h100, 8);

        // R2 bare mode
        for (int v = 0; v < 6; v++) lookup("R2 bare", 1'b0, 9'(v), 20'hFFFF0 + 20'(v * 3));

        // R1 R3 R8 basic hits across identifiers
        load_std();
        sweep("R1 R3 R8 std", 20'h100, 8);
        lookup("R2 bare over loaded", 1'b0, 9'd1, 20'h101);

        // R5 R8 identifier fences
        fence(1'b0, '0, 1'b1, 9'd0);
        sweep("R5 R8 fence id0", 20'h100, 8);
        load_std();
        fence(1'b0, '0, 1'b1, 9'd1);
        sweep("R5 fence id1", 20'h100, 8);

        // R6 page fences
        load_std();
        fence(1'b1, 20'h103, 1'b0, '0);
        fence(1'b1, 20'h101, 1'b0, '0);
        sweep("R6 fence page", 20'h100, 8);

        // R7 page+identifier fences
        load_std();
        fence(1'b1, 20'h103, 1'b1, 9'd0);
        fence(1'b1, 20'h100, 1'b1, 9'd0);
        fence(1'b1, 20'h101, 1'b1, 9'd0);
        fence(1'b1, 20'h104, 1'b1, 9'd1);
        sweep("R7 fence page id", 20'h100, 8);

        // R4 flush all, globals included
        load_std();
        fence(1'b0, '0, 1'b0, '0);
        sweep("R4 flush", 20'h100, 8);

        // R9 replacement: free slot first, then round robin
        load_std();
        fence(1'b1, 20'h106, 1'b0, '0);
        fill(20'h300, 22'h3000, 9'd1, 1'b0);
        for (int k = 1; k < 4; k++) fill(20'h300 + 20'(k), 22'h3000 + 22'(k), 9'd1, 1'b0);
        sweep("R9 victim std", 20'h100, 8);
        sweep("R9 victim new", 20'h300, 4);

        // R10 fence and refill together
        load_std();
        op(1'b1, 1'b0, '0, 1'b0, '0, 1'b1, 20'h400, 22'h4444, 9'd2, 1'b0);
        sweep("R10 flush+fill", 20'h100, 8);
        lookup("R10 fill kept", 1'b1, 9'd2, 20'h400);
        op(1'b1, 1'b1, 20'h400, 1'b0, '0, 1'b1, 20'h400, 22'h5555, 9'd2, 1'b0);
        lookup("R10 same page", 1'b1, 9'd2, 20'h400);

        // R13 wrap pages are distinct
        fence(1'b0, '0, 1'b0, '0);
        fill(20'hFFFFF, 22'h11111, 9'd1, 1'b0);
        fill(20'h00000, 22'h22222, 9'd1, 1'b0);
        lookup("R13 top page", 1'b1, 9'd1, 20'hFFFFF);
        lookup("R13 zero page", 1'b1, 9'd1, 20'h00000);
        lookup("R13 next page", 1'b1, 9'd1, 20'h00001);
        fence(1'b1, 20'hFFFFF, 1'b0, '0);
        lookup("R13 R6 top gone", 1'b1, 9'd1, 20'hFFFFF);
        lookup("R13 R6 zero kept", 1'b1, 9'd1, 20'h00000);

        // R12 idle cycle after traffic
        @(negedge clk);
        chk("R12 idle after traffic", {30'd0, rsp_valid_o, rsp_hit_o}, 32'd0);

        summary();
        $finish;
    end
endmodule